// File: doc/BRIEF.md
# Multi-Core Clock Ratio Controller

This block derives per-core clock enables from one shared parent clock. Each core receives a one-cycle enable pulse every R parent cycles, where R is the core's active ratio. The supported ratios are 1, 2 and 3. A gating cell downstream would consume the pulse. Software programs ratios through a small word-addressed register port.

A ratio update has three steps. First, software writes the new per-core fields into a staging register. Second, it sets a per-core reload-select bit in the control word. Third, it raises a single trigger bit. Only a 0-to-1 transition of the trigger schedules the update, and only for the selected cores. Each selected core then adopts its new ratio at its own next pulse boundary, so no enable interval is cut short. A status word reports, per core, whether the running ratio equals the staged one.

Top module: `core_ratio_ctrl`

## Requirements
- R1: After reset every core runs at ratio 1 with the enable high in every cycle. Reading the control word (address 0x0) returns 0. Reading the staging word (0xC) returns 0x01010101. Reading the status word (0x4) returns 0xF.
- R2: The staging word at 0xC holds one 6-bit field per core, with core c at bits [8c+5:8c]. Bits 6 and 7 of each byte read back as 0.
- R3: Writing the staging word alone never changes any core's running ratio.
- R4: A core's enable pulses once every E parent cycles. E is the core's effective ratio: a field of 0 gives 1, values 1 to 3 give themselves, and any value above 3 gives 3.
- R5: In the control word, bit 20+c selects core c for reload and bit 24 is the trigger; all other bits read as 0. On a rising edge of the trigger, every selected core takes its staged effective ratio. Cores not selected keep their ratio.
- R6: A switch takes effect only at a pulse boundary of the core being switched. Every enable interval therefore equals either the old ratio or the new ratio.
- R7: While the trigger stays high, later staging writes are not applied. A new update needs the trigger to go low and then high again.
- R8: Bit c of the status word (0x4) is 1 exactly when core c's running ratio equals the effective value of its staged field. Once a triggered update has completed, that bit reads 1.
- R9: Writes to 0x4 and 0x8 have no effect, and reads of 0x8 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| core_en_o | output | 4 | Per-core divided clock enable |

## Verification
The assertions take three things for granted. Every running ratio lies between 1 and the maximum. Reload scheduling is driven only by the registered trigger level. Once an update is pending, software waits for it to land before depending on the status bit. The stimulus always waits well over three parent cycles after each trigger before measuring enable intervals or reading status. It lowers the trigger before every fresh update except in the hold-high case that R7 targets. All writes are single-cycle strobes to aligned word addresses.

// File: rtl/core_ratio_pkg.sv
package core_ratio_pkg;
  localparam int unsigned OFF_CTRL     = 'h0;
  localparam int unsigned OFF_STAT     = 'h4;
  localparam int unsigned OFF_DIV      = 'hC;
  localparam int unsigned RELOAD_LSB   = 20;
  localparam int unsigned TRIG_BIT     = 24;
  localparam int unsigned FIELD_STRIDE = 8;
endpackage

// File: rtl/core_ratio_regs.sv
module core_ratio_regs
  import core_ratio_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [N_CORES-1:0]              status_i,
  output logic [N_CORES-1:0][FIELD_W-1:0] staged_o,
  output logic [N_CORES-1:0]              reload_o,
  output logic                            trig_o
);
  logic sel_ctrl, sel_stat, sel_div;
  logic unused_wdata;

  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));
  assign sel_div  = (addr_i == ADDR_W'(OFF_DIV));
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= '0;
      trig_o   <= 1'b0;
      for (int c = 0; c < N_CORES; c++) staged_o[c] <= FIELD_W'(1);
    end else if (wr_en_i) begin
      if (sel_ctrl) begin
        for (int c = 0; c < N_CORES; c++) reload_o[c] <= wdata_i[RELOAD_LSB + c];
        trig_o <= wdata_i[TRIG_BIT];
      end
      if (sel_div) begin
        for (int c = 0; c < N_CORES; c++)
          staged_o[c] <= wdata_i[FIELD_STRIDE*c +: FIELD_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      for (int c = 0; c < N_CORES; c++) rdata_o[RELOAD_LSB + c] = reload_o[c];
      rdata_o[TRIG_BIT] = trig_o;
    end
    if (sel_stat) rdata_o[N_CORES-1:0] = status_i;
    if (sel_div) begin
      for (int c = 0; c < N_CORES; c++) rdata_o[FIELD_STRIDE*c +: FIELD_W] = staged_o[c];
    end
  end
endmodule

// File: rtl/core_ratio_div.sv
module core_ratio_div #(
  parameter int unsigned FIELD_W   = 6,
  parameter int unsigned MAX_RATIO = 3,
  parameter int unsigned RATIO_W   = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               en_o,
  output logic               match_o,
  output logic               pend_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] eff, pend_ratio_q, cnt_q;
  logic               wrap;

  // clamp staged field: 0 -> 1, above max -> max
  always_comb begin
    if (field_i == '0)                       eff = RATIO_W'(1);
    else if (field_i > FIELD_W'(MAX_RATIO))  eff = RATIO_W'(MAX_RATIO);
    else                                     eff = field_i[RATIO_W-1:0];
  end

  assign wrap    = (cnt_q == ratio_o - RATIO_W'(1));
  assign en_o    = wrap;
  assign match_o = (ratio_o == eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o      <= RATIO_W'(1);
      cnt_q        <= '0;
      pend_o       <= 1'b0;
      pend_ratio_q <= RATIO_W'(1);
    end else begin
      if (wrap) begin
        cnt_q <= '0;
        if (pend_o) begin
          ratio_o <= pend_ratio_q;
          pend_o  <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
      if (load_i) begin
        pend_o       <= 1'b1;
        pend_ratio_q <= eff;
      end
    end
  end
endmodule

// File: rtl/core_ratio_ctrl.sv
module core_ratio_ctrl #(
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned FIELD_W   = 6,
  parameter int unsigned MAX_RATIO = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_CORES-1:0] core_en_o
);
  localparam int unsigned RATIO_W = $clog2(MAX_RATIO + 1);

  logic [N_CORES-1:0][FIELD_W-1:0] staged;
  logic [N_CORES-1:0][RATIO_W-1:0] act_ratio;
  logic [N_CORES-1:0]              reload, status, pend;
  logic                            trig_bit, trig_q, trig_rise;

  core_ratio_regs #(
    .N_CORES(N_CORES), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .status_i (status),
    .staged_o (staged),
    .reload_o (reload),
    .trig_o   (trig_bit)
  );

  // level-held trigger: act only on its 0->1 transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_bit;
  end
  assign trig_rise = trig_bit & ~trig_q;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    core_ratio_div #(
      .FIELD_W(FIELD_W), .MAX_RATIO(MAX_RATIO), .RATIO_W(RATIO_W)
    ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (trig_rise & reload[c]),
      .field_i (staged[c]),
      .en_o    (core_en_o[c]),
      .match_o (status[c]),
      .pend_o  (pend[c]),
      .ratio_o (act_ratio[c])
    );
  end
endmodule

// File: rtl/core_ratio_ctrl_chk.sv
module core_ratio_ctrl_chk #(
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned MAX_RATIO = 3,
  parameter int unsigned RATIO_W   = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_CORES-1:0]              core_en_i,
  input logic [N_CORES-1:0][RATIO_W-1:0] act_i,
  input logic [N_CORES-1:0]              pend_i,
  input logic                            trig_i
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    AST_RATIO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[c] != '0 && act_i[c] <= RATIO_W'(MAX_RATIO)); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_en_i[c] && act_i[c] != RATIO_W'(1) && !pend_i[c] |=> !core_en_i[c]); // R4
    AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_i[c]) |-> $past(core_en_i[c])); // R6
    AST_NO_REAPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[c]) |-> $past(trig_i) && !$past(trig_i, 2)); // R7
  end
endmodule

bind core_ratio_ctrl core_ratio_ctrl_chk #(
  .N_CORES(N_CORES), .MAX_RATIO(MAX_RATIO), .RATIO_W(RATIO_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .core_en_i (core_en_o),
  .act_i     (act_ratio),
  .pend_i    (pend),
  .trig_i    (trig_bit)
);

// File: tb/core_ratio_ctrl_test.sv
module core_ratio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  en;

  int n_chk = 0, n_fail = 0;
  int exp_r[4];
  int stg[4];
  bit done = 1'b0;

  bit mon_on = 1'b0;
  int gap = 0, min_gap = 99;

  always #5 clk = ~clk;

  core_ratio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .core_en_o(en)
  );

  always @(negedge clk) begin
    if (!mon_on) begin
      gap = 0; min_gap = 99;
    end else if (en[0]) begin
      if (gap > 0 && gap < min_gap) min_gap = gap;
      gap = 1;
    end else if (gap > 0) gap++;
  end

  function automatic int clampr(int f);
    return (f == 0) ? 1 : (f > 3 ? 3 : f);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic measure(int c, output int per);
    int n = 0;
    @(negedge clk);
    while (!en[c] && n < 20) begin @(negedge clk); n++; end
    per = 1;
    @(negedge clk);
    while (!en[c] && per < 20) begin per++; @(negedge clk); end
  endtask

  task automatic stage_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'(stg[k]);
    wr(4'hC, w);
  endtask

  task automatic check_all(string req);
    int p;
    logic [31:0] s;
    for (int k = 0; k < 4; k++) begin
      measure(k, p);
      check(p == exp_r[k], req, p, exp_r[k]);
    end
    rd(4'h4, s);
    for (int k = 0; k < 4; k++)
      check(s[k] == (exp_r[k] == clampr(stg[k])), "R8 status", int'(s[k]),
            int'(exp_r[k] == clampr(stg[k])));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p;
    int vals[7] = '{0, 1, 2, 3, 4, 63, 2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin exp_r[k] = 1; stg[k] = 1; end

    // R1 reset state
    #1 check(en == 4'hF, "R1 enables", int'(en), 'hF);
    rd(4'h0, d); check(d == 32'h0, "R1 ctrl", d, 0);
    rd(4'hC, d); check(d == 32'h01010101, "R1 staging", d, 'h01010101);
    rd(4'h4, d); check(d == 32'hF, "R1 status", d, 'hF);

    // R5 control readback: only reload and trigger bits exist
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check(d == 32'h01F0_0000, "R5 ctrl readback", d, 'h01F00000);
    wr(4'h0, 32'h0);

    // R2 field width masking
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); check(d == 32'h3F3F3F3F, "R2 field mask", d, 'h3F3F3F3F);
    // R9 writes to status / unmapped ignored, unmapped reads zero
    wr(4'h4, 32'h0); wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); check(d == 32'h0, "R9 unmapped read", d, 0);
    rd(4'h4, d); check(d == 32'h0, "R9 status after write", d, 0);
    rd(4'hC, d); check(d == 32'h3F3F3F3F, "R9 staging intact", d, 'h3F3F3F3F);
    // R3 staging alone does not change ratios
    measure(0, p); check(p == 1, "R3 staged only", p, 1);
    wr(4'hC, 32'h01010101);

    // R4 R5 sweep: each core, each field value; other fields staged at 3
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 7; i++) begin
        for (int k = 0; k < 4; k++) stg[k] = (k == c) ? vals[i] : 3;
        stage_word();
        measure(c, p); check(p == exp_r[c], "R3 no apply before trigger", p, exp_r[c]);
        wr(4'h0, 32'(1) << (20 + c));
        wr(4'h0, (32'(1) << (20 + c)) | (32'(1) << 24));
        repeat (10) @(negedge clk);
        wr(4'h0, 32'h0);
        exp_r[c] = clampr(vals[i]);
        check_all("R4 R5 period");
        rd(4'hC, d);
        check(d[8*c +: 8] == 8'(vals[i]), "R2 field position", int'(d[8*c +: 8]), vals[i]);
      end
    end

    // R7 held trigger does not reapply
    for (int k = 0; k < 4; k++) stg[k] = 2;
    stage_word();
    wr(4'h0, 32'h01F0_0000);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) exp_r[k] = 2;
    check_all("R7 first apply");
    for (int k = 0; k < 4; k++) stg[k] = 3;
    stage_word();
    repeat (20) @(negedge clk);
    check_all("R7 held trigger");
    wr(4'h0, 32'h00F0_0000);
    wr(4'h0, 32'h01F0_0000);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) exp_r[k] = 3;
    check_all("R7 re-armed trigger");
    wr(4'h0, 32'h0);

    // R6 switch 3 -> 2 on core 0 keeps every interval whole
    mon_on = 1'b1;
    repeat (8) @(negedge clk);
    stg[0] = 2;
    stage_word();
    wr(4'h0, 32'h0110_0000);
    repeat (30) @(negedge clk);
    check(min_gap == 2, "R6 min interval", min_gap, 2);
    mon_on = 1'b0;
    wr(4'h0, 32'h0);
    exp_r[0] = 2;
    check_all("R6 after switch");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule